// File: doc/BRIEF.md
# I2C Stuck-Line Timeout Watchdog

This block sits beside the state machine of an I2C target. It recovers that state machine when a transfer stalls. It takes the synchronized SCL and SDA levels and one-cycle START and STOP strobes from the protocol decoder. It also takes an enable level that comes from a control register bit kept elsewhere. That bit is expected to come out of reset set, so recovery is on by default.

Once a valid START has been seen, the watchdog times how long the bus has had at least one line held low. If SCL or SDA stays low for longer than a threshold while the enable is high, the watchdog does two things:

- It sends a single-cycle reset pulse to the target logic.
- It holds a release request on the SDA driver, so that SDA goes back to being an input.

From then on it ignores all bus activity until the next START. It does not time the total length of a transfer, and it never runs while the bus is idle.

The state machine has three states:

- `WD_IDLE`: no transfer is in progress.
- `WD_ACTIVE`: a transfer is armed and being timed.
- `WD_TRIPPED`: a timeout has fired and the block is waiting for a START.

Its transitions are:

- **arm**: `WD_IDLE` to `WD_ACTIVE` on a START without a STOP.
- **finish**: `WD_ACTIVE` to `WD_IDLE` on a STOP.
- **restart**: `WD_ACTIVE` to itself on a repeated START.
- **expire**: `WD_ACTIVE` to `WD_TRIPPED` when the low window runs out.
- **rearm**: `WD_TRIPPED` to `WD_ACTIVE` on a START.

The threshold `LIMIT_CYC` is given in system-clock cycles. The default is 29 ms at 125 MHz.

Top module: `i2c_stall_watchdog`

## Requirements
- R1: While reset is held and in the first cycle after it, `xfer_active`, `tgt_reset` and `sda_release` are all 0.
- R2: A START strobe without a STOP in the same cycle, in the idle state, sets `xfer_active` from the next cycle onward.
- R3: A STOP strobe while a transfer is armed clears `xfer_active` in the next cycle. After that, low lines never cause a timeout.
- R4: While a transfer is armed and the enable is high, a low level on SCL or SDA sampled on LIMIT_CYC+1 consecutive clock edges fires the timeout. If the lines are low on only LIMIT_CYC consecutive edges, the timeout does not fire.
- R5: The low window counts a low on SCL alone, on SDA alone, or on both. Any edge on which both lines are high restarts the window from zero.
- R6: While the enable is low, the timeout never fires and the window is held at zero. After the enable returns high, a full LIMIT_CYC+1 low edges are needed again.
- R7: When the timeout fires, `tgt_reset` is 1 for exactly one cycle, the cycle after the expiring edge. In that same cycle `sda_release` becomes 1 and `xfer_active` becomes 0.
- R8: After a timeout, STOP strobes and low lines are ignored: `sda_release` stays 1 and no further pulse occurs. The next START clears `sda_release` and sets `xfer_active` from the following cycle.
- R9: A repeated START while a transfer is armed restarts the low window from zero.
- R10: When START and STOP arrive in the same cycle, STOP wins in the idle and armed states. In the tripped state the START is honored.
- R11: While idle, low lines never cause a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Timeout enable from control register bit |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| start_evt | input | 1 | One-cycle START condition strobe |
| stop_evt | input | 1 | One-cycle STOP condition strobe |
| xfer_active | output | 1 | A transfer is armed and being timed |
| tgt_reset | output | 1 | One-cycle reset pulse to the target logic |
| sda_release | output | 1 | Force the SDA driver released, held until the next START |

## Verification
The assertions assume that START and STOP arrive as single-cycle strobes that are synchronous to `clk`. They also assume that the enable and line levels are already synchronized, so any combination of them may appear on any edge. On that basis the assertions check sequencing that holds under any input pattern: the pulse length, how the pulse relates to the release, and how the strobes move the block between states. They never assume a legal I2C waveform.

The stimulus changes inputs only at the falling clock edge. It mixes random strobes with long random stall periods, so that windows run both just short of and just past the small threshold used in the bench. Directed sequences cover the exact boundary, the enable, the repeated START and the simultaneous strobes.

// File: rtl/i2c_wd_pkg.sv
package i2c_wd_pkg;

    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_ACTIVE  = 2'd1,
        WD_TRIPPED = 2'd2
    } wd_state_t;

    function automatic int wd_cnt_width(input int limit);
        wd_cnt_width = (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/wd_low_timer.sv
module wd_low_timer #(
    parameter int LIMIT_CYC = 3625000,
    parameter int CNT_W     = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic line_low,
    output logic expire
);

    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT_CYC);

    logic [CNT_W-1:0] low_cnt;
    logic             at_limit;

    assign at_limit = (low_cnt == LIM);
    assign expire   = count_en && line_low && at_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!count_en || !line_low || at_limit) begin
            low_cnt <= '0;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wd_xfer_fsm.sv
module wd_xfer_fsm
    import i2c_wd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_evt,
    input  logic stop_evt,
    input  logic expire,
    output logic armed,
    output logic tripped,
    output logic enter_trip
);

    wd_state_t state_q;
    wd_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: arm, finish, restart, expire, rearm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (start_evt && !stop_evt) state_d = WD_ACTIVE;
            end
            WD_ACTIVE: begin
                if (stop_evt)       state_d = WD_IDLE;
                else if (start_evt) state_d = WD_ACTIVE;
                else if (expire)    state_d = WD_TRIPPED;
            end
            WD_TRIPPED: begin
                if (start_evt) state_d = WD_ACTIVE;
            end
            default: state_d = WD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        armed      = 1'b0;
        tripped    = 1'b0;
        enter_trip = 1'b0;
        unique case (state_q)
            WD_IDLE:    ;
            WD_ACTIVE: begin
                armed      = 1'b1;
                enter_trip = (state_d == WD_TRIPPED);
            end
            WD_TRIPPED: tripped = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/wd_pulse_gen.sv
module wd_pulse_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else begin
            pulse <= fire;
        end
    end

endmodule

// File: rtl/i2c_stall_watchdog.sv
module i2c_stall_watchdog
    import i2c_wd_pkg::*;
#(
    parameter int LIMIT_CYC = 3625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_in,
    input  logic sda_in,
    input  logic start_evt,
    input  logic stop_evt,
    output logic xfer_active,
    output logic tgt_reset,
    output logic sda_release
);

    localparam int CNT_W = wd_cnt_width(LIMIT_CYC);

    logic line_low;
    logic count_en;
    logic expire;
    logic enter_trip;

    assign line_low = !scl_in || !sda_in;
    assign count_en = xfer_active && enable && !start_evt && !stop_evt;

    wd_low_timer #(
        .LIMIT_CYC (LIMIT_CYC),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .line_low (line_low),
        .expire   (expire)
    );

    wd_xfer_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .expire     (expire),
        .armed      (xfer_active),
        .tripped    (sda_release),
        .enter_trip (enter_trip)
    );

    wd_pulse_gen u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (enter_trip),
        .pulse (tgt_reset)
    );

endmodule

// File: rtl/i2c_stall_watchdog_chk.sv
module i2c_stall_watchdog_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic start_evt,
    input logic stop_evt,
    input logic xfer_active,
    input logic tgt_reset,
    input logic sda_release
);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_reset |=> !tgt_reset);                                   // R7

    AST_PULSE_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_reset |-> (sda_release && !xfer_active));                // R7

    AST_PULSE_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> !tgt_reset);                                // R11

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !tgt_reset);                                     // R6

    AST_RELEASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_release && !start_evt) |=> (sda_release && !tgt_reset)); // R8

    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !stop_evt) |=> (xfer_active && !sda_release));  // R2

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !sda_release) |=> !xfer_active);                 // R3

    AST_STATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_active && sda_release));                               // R10

endmodule

bind i2c_stall_watchdog i2c_stall_watchdog_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .xfer_active (xfer_active),
    .tgt_reset   (tgt_reset),
    .sda_release (sda_release)
);

// File: tb/tb_i2c_stall_watchdog.sv
`timescale 1ns/1ps
module tb_i2c_stall_watchdog;

    localparam int LIM = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic start_evt = 1'b0;
    logic stop_evt = 1'b0;
    logic xfer_active;
    logic tgt_reset;
    logic sda_release;

    int n_vec = 0;
    int n_bad = 0;

    // model: 0 idle, 1 armed, 2 tripped
    typedef struct packed {
        logic [1:0] st;
        logic [7:0] cnt;
        logic       rst;
    } model_t;

    model_t m = '0;

    always #4 clk = ~clk;

    i2c_stall_watchdog #(.LIMIT_CYC(LIM)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .scl_in      (scl_in),
        .sda_in      (sda_in),
        .start_evt   (start_evt),
        .stop_evt    (stop_evt),
        .xfer_active (xfer_active),
        .tgt_reset   (tgt_reset),
        .sda_release (sda_release)
    );

    function automatic model_t model_next(model_t c, bit st, bit sp, bit en, bit scl, bit sda);
        model_t n;
        bit low;
        low   = !scl || !sda;
        n     = c;
        n.rst = 1'b0;
        n.cnt = 8'd0;
        case (c.st)
            2'd0: if (st && !sp) n.st = 2'd1;
            2'd1: begin
                if (sp)            n.st = 2'd0;
                else if (st)       n.st = 2'd1;
                else if (en && low) begin
                    if (c.cnt == 8'(LIM)) begin
                        n.st  = 2'd2;
                        n.rst = 1'b1;
                    end else begin
                        n.cnt = c.cnt + 8'd1;
                    end
                end
            end
            default: if (st) n.st = 2'd1;
        endcase
        return n;
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive at falling edge, update model at rising edge, compare at falling edge
    task automatic cyc(input bit st, input bit sp, input bit en, input bit scl, input bit sda);
        start_evt = st;
        stop_evt  = sp;
        enable    = en;
        scl_in    = scl;
        sda_in    = sda;
        @(posedge clk);
        m = model_next(m, st, sp, en, scl, sda);
        @(negedge clk);
        chk(xfer_active, m.st == 2'd1, "R2/R3 xfer_active");
        chk(tgt_reset,   m.rst,        "R4/R7 tgt_reset");
        chk(sda_release, m.st == 2'd2, "R7/R8 sda_release");
    endtask

    task automatic lows(input int n, input bit en, input bit scl, input bit sda);
        for (int i = 0; i < n; i++) cyc(0, 0, en, scl, sda);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        bit stall;
        void'($urandom(32'h1C2D_3A4B));
        repeat (3) @(negedge clk);
        chk(xfer_active, 1'b0, "R1 reset xfer_active");
        chk(tgt_reset,   1'b0, "R1 reset tgt_reset");
        chk(sda_release, 1'b0, "R1 reset sda_release");
        rst_n = 1'b1;
        @(negedge clk);
        chk(xfer_active, 1'b0, "R1 post-reset xfer_active");

        // R11: idle lows never fire
        lows(40, 1, 0, 0);
        chk(tgt_reset, 1'b0, "R11 idle lows");

        // R2: START arms
        cyc(1, 0, 1, 1, 0);
        chk(xfer_active, 1'b1, "R2 armed after START");

        // R4: LIM lows then high: no fire
        lows(LIM, 1, 1, 0);
        cyc(0, 0, 1, 1, 1);
        chk(tgt_reset, 1'b0, "R4 LIM lows no fire");
        // R4/R7: LIM+1 lows fire
        lows(LIM + 1, 1, 1, 0);
        chk(tgt_reset,   1'b1, "R4 fire after LIM+1 lows");
        chk(sda_release, 1'b1, "R7 release with pulse");
        chk(xfer_active, 1'b0, "R7 disarmed on fire");
        cyc(0, 0, 1, 1, 0);
        chk(tgt_reset,   1'b0, "R7 single-cycle pulse");

        // R8: ignored until START
        cyc(0, 1, 1, 1, 1);
        lows(30, 1, 0, 0);
        chk(sda_release, 1'b1, "R8 release held");
        chk(tgt_reset,   1'b0, "R8 no second pulse");
        cyc(1, 0, 1, 1, 0);
        chk(sda_release, 1'b0, "R8 START clears release");
        chk(xfer_active, 1'b1, "R8 START rearms");

        // R5: mixed lines, break restarts window
        lows(8, 1, 1, 0);
        lows(4, 1, 0, 1);
        cyc(0, 0, 1, 1, 1);
        lows(LIM, 1, 0, 0);
        chk(tgt_reset, 1'b0, "R5 window restarted by high");
        lows(1, 1, 0, 1);
        chk(tgt_reset, 1'b1, "R5 SCL-only low fires");
        cyc(1, 0, 1, 1, 1);

        // R6: enable low holds window cleared
        lows(30, 0, 0, 0);
        chk(tgt_reset, 1'b0, "R6 disabled no fire");
        lows(LIM, 1, 0, 0);
        cyc(0, 0, 1, 1, 1);
        chk(tgt_reset, 1'b0, "R6 window restarts after enable");

        // R9: repeated START restarts window
        lows(10, 1, 1, 0);
        cyc(1, 0, 1, 1, 0);
        lows(10, 1, 1, 0);
        chk(tgt_reset,   1'b0, "R9 repeated START restart");
        chk(xfer_active, 1'b1, "R9 still armed");

        // R3: STOP ends, lows after never fire
        cyc(0, 1, 1, 1, 1);
        chk(xfer_active, 1'b0, "R3 STOP disarms");
        lows(30, 1, 1, 0);
        chk(tgt_reset, 1'b0, "R3 no fire after STOP");

        // R10: simultaneous strobes
        cyc(1, 1, 1, 1, 1);
        chk(xfer_active, 1'b0, "R10 idle STOP wins");
        cyc(1, 0, 1, 1, 1);
        cyc(1, 1, 1, 1, 1);
        chk(xfer_active, 1'b0, "R10 armed STOP wins");
        cyc(1, 0, 1, 1, 1);
        lows(LIM + 1, 1, 0, 0);
        cyc(1, 1, 1, 1, 1);
        chk(xfer_active, 1'b1, "R10 tripped START wins");

        // random phase
        stall = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            bit st, sp, en, scl, sda;
            if ($urandom_range(99) < 6) stall = !stall;
            st  = ($urandom_range(99) < 3);
            sp  = ($urandom_range(99) < 2);
            en  = ($urandom_range(99) < 92);
            scl = stall ? 1'b0 : ($urandom_range(99) < 75);
            sda = stall ? ($urandom_range(99) < 50) : ($urandom_range(99) < 80);
            cyc(st, sp, en, scl, sda);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule